// File: doc/BRIEF.md
# Status-Flag ALU

This block is an integer arithmetic and logic unit for a processor datapath. It takes two 32-bit operands, a three-bit operation code, a two-bit width code and a carry input, and it drives the result combinationally. Beside the result it computes six status bits: carry, parity, auxiliary carry, zero, sign and overflow. It computes them at the width the current operation selects, which is 8, 16 or 32 bits.

The six status bits are captured together in a flags register. The register loads only on a clock edge where the write strobe is high. A pipeline can therefore issue operations that compute a value without disturbing the stored flags. Operand bits above the active width are ignored, and result bits above it read as zero.

Top module: `status_alu`

## Requirements
- R1: opSel 0 (add) gives A+B, and opSel 1 (add with carry) gives A+B+carryIn. Both are taken modulo 2^W. flagsQ bit 0 (carry) is set when the unsigned sum does not fit in W bits.
- R2: opSel 2 (subtract) gives A-B, and opSel 3 (subtract with borrow) gives A-B-carryIn. Both are taken modulo 2^W. The carry bit signals a borrow: the unsigned A is smaller than B plus the borrow-in.
- R3: For opSel 0 to 3, flagsQ bit 5 (overflow) is set exactly when the true signed result of the W-bit operands lies outside the two's-complement range of W bits.
- R4: flagsQ bit 2 (auxiliary carry) is set when the low nibble of an add carries into bit 4, or when the low nibble of a subtract borrows from bit 4. The carry or borrow input counts wherever R1 or R2 uses it.
- R5: opSel 4, 5, 6 and 7 give A AND B, A OR B, A XOR B and NOT A. For these operations the carry, overflow and auxiliary carry bits are all 0.
- R6: flagsQ bit 4 (sign) equals bit W-1 of the result. flagsQ bit 3 (zero) is set when all W result bits are 0.
- R7: flagsQ bit 1 (parity) is set when the low 8 bits of the result hold an even number of ones, whatever W is.
- R8: widthSel 0 selects W=8 and widthSel 1 selects W=16. Values 2 and 3 select W=32. Operand bits at and above W have no effect, and result bits at and above W are 0.
- R9: The flags register resets to all zeros. It loads all six bits on a rising clock edge where flagWe is high, and holds its value otherwise.
- R10: carryIn has no effect on any operation other than opSel 1 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 32 | First operand (minuend for subtract) |
| opB | input | 32 | Second operand |
| opSel | input | 3 | Operation code, see R1, R2 and R5 |
| widthSel | input | 2 | Operand width code, see R8 |
| carryIn | input | 1 | Carry or borrow input for opSel 1 and 3 |
| flagWe | input | 1 | Flags register load strobe |
| result | output | 32 | Combinational result, zero above the active width |
| flagsQ | output | 6 | Registered flags: [0] carry, [1] parity, [2] aux carry, [3] zero, [4] sign, [5] overflow |

## Verification
The checker relates each loaded flag to the previous cycle's result port. This relies on opA, opB, opSel and widthSel being settled and known at every rising edge where flagWe is high. It also relies on those inputs not changing between the edge and the point where the result is sampled. The bench meets this by changing every input only on the falling clock edge and holding it for a full cycle. It also leaves reset asserted with all inputs at zero until the flags register is checked. Random stimulus covers all eight operation codes and all four width codes, including the duplicate code for 32 bits. It also toggles flagWe, so the assertions see both loading cycles and holding cycles.

// File: rtl/status_alu_pkg.sv
`timescale 1ns/1ps
package status_alu_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_W  = 3;   // number of selectable widths: 8 << index
  localparam int NIB_W  = 4;   // aux carry boundary
  localparam int PAR_W  = 8;   // parity span
  localparam int FLAG_W = 6;
  localparam int OP_W   = 3;
  localparam int WS_W   = 2;

  localparam int FL_C = 0;
  localparam int FL_P = 1;
  localparam int FL_A = 2;
  localparam int FL_Z = 3;
  localparam int FL_S = 4;
  localparam int FL_O = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_NOT = 3'd7
  } op_e;

  typedef enum logic [1:0] { LG_AND, LG_OR, LG_XOR, LG_NOT } logic_e;

  typedef struct packed {
    logic             doSub;
    logic             useCin;
    logic             isLogic;
    logic_e           logicSel;
    logic [NUM_W-1:0] widthOh;
    logic             loadFlags;
  } ctrl_t;
endpackage

// File: rtl/status_alu_ctrl.sv
`timescale 1ns/1ps
module status_alu_ctrl
  import status_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  input  logic [WS_W-1:0] widthSel,
  input  logic            flagWe,
  output ctrl_t           ctl
);
  op_e opCode;
  assign opCode = op_e'(opSel);

  always_comb begin
    ctl = '0;
    ctl.loadFlags = flagWe;
    unique case (opCode)
      OP_ADD: begin ctl.doSub = 1'b0; ctl.useCin = 1'b0; end
      OP_ADC: begin ctl.doSub = 1'b0; ctl.useCin = 1'b1; end
      OP_SUB: begin ctl.doSub = 1'b1; ctl.useCin = 1'b0; end
      OP_SBB: begin ctl.doSub = 1'b1; ctl.useCin = 1'b1; end
      OP_AND: begin ctl.isLogic = 1'b1; ctl.logicSel = LG_AND; end
      OP_OR:  begin ctl.isLogic = 1'b1; ctl.logicSel = LG_OR;  end
      OP_XOR: begin ctl.isLogic = 1'b1; ctl.logicSel = LG_XOR; end
      OP_NOT: begin ctl.isLogic = 1'b1; ctl.logicSel = LG_NOT; end
      default: ctl.isLogic = 1'b0;
    endcase
    case (widthSel)
      2'd0:    ctl.widthOh = NUM_W'(1);
      2'd1:    ctl.widthOh = NUM_W'(2);
      default: ctl.widthOh = NUM_W'(1) << (NUM_W - 1);
    endcase
  end
endmodule

// File: rtl/status_alu_dp.sv
`timescale 1ns/1ps
module status_alu_dp
  import status_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  ctrl_t             ctl,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsQ
);
  // per-width slices, built once per selectable width
  logic [DATA_W-1:0] maskPer [NUM_W];
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] aM, bM;
  logic [DATA_W:0]   sumWide, cinWide;
  logic [NIB_W:0]    nibWide, cinNib;
  logic [DATA_W-1:0] logicRes, rawRes;
  logic [NUM_W-1:0]  carryAt, signA, signB, signR;
  logic              cinEff, carryBit, sA, sB, sR, ovBit;
  logic [FLAG_W-1:0] flagsNext;

  for (genvar gi = 0; gi < NUM_W; gi++) begin : g_width
    localparam int W = 8 << gi;
    assign maskPer[gi] = DATA_W'((64'd1 << W) - 64'd1);
    assign carryAt[gi] = sumWide[W];
    assign signA[gi]   = aM[W-1];
    assign signB[gi]   = bM[W-1];
    assign signR[gi]   = result[W-1];
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < NUM_W; i++)
      if (ctl.widthOh[i]) mask = mask | maskPer[i];
  end

  assign aM      = opA & mask;
  assign bM      = opB & mask;
  assign cinEff  = ctl.useCin & carryIn;
  assign cinWide = {{DATA_W{1'b0}}, cinEff};
  assign cinNib  = {{NIB_W{1'b0}}, cinEff};

  // one shared adder; operands are zero above the width, so the bit at
  // index W holds the carry (add) or the borrow (subtract)
  always_comb begin
    if (ctl.doSub) begin
      sumWide = {1'b0, aM} - {1'b0, bM} - cinWide;
      nibWide = {1'b0, aM[NIB_W-1:0]} - {1'b0, bM[NIB_W-1:0]} - cinNib;
    end else begin
      sumWide = {1'b0, aM} + {1'b0, bM} + cinWide;
      nibWide = {1'b0, aM[NIB_W-1:0]} + {1'b0, bM[NIB_W-1:0]} + cinNib;
    end
  end

  always_comb begin
    unique case (ctl.logicSel)
      LG_AND:  logicRes = aM & bM;
      LG_OR:   logicRes = aM | bM;
      LG_XOR:  logicRes = aM ^ bM;
      default: logicRes = ~aM;
    endcase
  end

  assign rawRes = ctl.isLogic ? logicRes : sumWide[DATA_W-1:0];
  assign result = rawRes & mask;

  assign carryBit = |(carryAt & ctl.widthOh);
  assign sA       = |(signA & ctl.widthOh);
  assign sB       = |(signB & ctl.widthOh);
  assign sR       = |(signR & ctl.widthOh);
  assign ovBit    = ctl.doSub ? ((sA != sB) && (sR != sA))
                              : ((sA == sB) && (sR != sA));

  always_comb begin
    flagsNext       = '0;
    flagsNext[FL_C] = !ctl.isLogic && carryBit;
    flagsNext[FL_P] = ~^result[PAR_W-1:0];
    flagsNext[FL_A] = !ctl.isLogic && nibWide[NIB_W];
    flagsNext[FL_Z] = (result == '0);
    flagsNext[FL_S] = sR;
    flagsNext[FL_O] = !ctl.isLogic && ovBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              flagsQ <= '0;
    else if (ctl.loadFlags) flagsQ <= flagsNext;
  end
endmodule

// File: rtl/status_alu.sv
`timescale 1ns/1ps
module status_alu
  import status_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OP_W-1:0]   opSel,
  input  logic [WS_W-1:0]   widthSel,
  input  logic              carryIn,
  input  logic              flagWe,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsQ
);
  ctrl_t ctl;

  status_alu_ctrl u_ctrl (
    .opSel(opSel), .widthSel(widthSel), .flagWe(flagWe), .ctl(ctl)
  );

  status_alu_dp u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .ctl(ctl), .result(result), .flagsQ(flagsQ)
  );
endmodule

// File: rtl/status_alu_chk.sv
`timescale 1ns/1ps
module status_alu_chk
  import status_alu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [OP_W-1:0]   opSel,
  input logic [WS_W-1:0]   widthSel,
  input logic              carryIn,
  input logic              flagWe,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flagsQ
);
  logic msbNow;
  assign msbNow = (widthSel == 2'd0) ? result[7] :
                  (widthSel == 2'd1) ? result[15] : result[DATA_W-1];

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |=> $stable(flagsQ));

  p_logic_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && opSel[2]) |=> (flagsQ[FL_C] == 1'b0 && flagsQ[FL_O] == 1'b0
                              && flagsQ[FL_A] == 1'b0));

  p_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagWe |=> (flagsQ[FL_Z] == ($past(result) == '0)));

  p_sign_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagWe |=> (flagsQ[FL_S] == $past(msbNow)));

  p_parity_r7: assert property (@(posedge clk) disable iff (!rstN)
    flagWe |=> (flagsQ[FL_P] == ~^$past(result[PAR_W-1:0])));

  p_upper8_r8: assert property (@(posedge clk) disable iff (!rstN)
    (widthSel == 2'd0) |-> (result[DATA_W-1:8] == '0));

  p_upper16_r8: assert property (@(posedge clk) disable iff (!rstN)
    (widthSel == 2'd1) |-> (result[DATA_W-1:16] == '0));
endmodule

bind status_alu status_alu_chk u_chk (.*);

// File: tb/status_alu_test.sv
`timescale 1ns/1ps
module status_alu_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [2:0]  opSel = '0;
  logic [1:0]  widthSel = '0;
  logic        carryIn = 1'b0, flagWe = 1'b0;
  logic [31:0] result;
  logic [5:0]  flagsQ;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [5:0] heldFlags = '0;

  logic [31:0] qRes[$];
  logic [5:0]  qFlg[$];
  string       qTag[$];

  status_alu uut (.clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
                  .widthSel(widthSel), .carryIn(carryIn), .flagWe(flagWe),
                  .result(result), .flagsQ(flagsQ));

  always #5 clk = ~clk;

  // reference model written from the requirements
  function automatic void model(input logic [31:0] a, b, input logic [2:0] op,
                                input logic [1:0] ws, input logic cin,
                                output logic [31:0] r, output logic [5:0] f);
    longint w, mask, ua, ub, c, sa, sb, full, sfull, smax, smin, sgn;
    logic cy, ov, ax;
    w = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    mask = (longint'(1) << w) - 1;
    ua = longint'(a) & mask;
    ub = longint'(b) & mask;
    c  = (op == 3'd1 || op == 3'd3) ? longint'(cin) : 0;
    sgn = longint'(1) << (w - 1);
    sa = (ua >= sgn) ? ua - (mask + 1) : ua;
    sb = (ub >= sgn) ? ub - (mask + 1) : ub;
    smax = sgn - 1;
    smin = -sgn;
    cy = 0; ov = 0; ax = 0;
    if (op < 3'd2) begin
      full = ua + ub + c; sfull = sa + sb + c;
      cy = full > mask; ov = (sfull > smax) || (sfull < smin);
      ax = ((ua & 15) + (ub & 15) + c) > 15;
    end else if (op < 3'd4) begin
      full = ua - ub - c; sfull = sa - sb - c;
      cy = full < 0; ov = (sfull > smax) || (sfull < smin);
      ax = (ua & 15) < ((ub & 15) + c);
    end else begin
      case (op)
        3'd4: full = ua & ub;
        3'd5: full = ua | ub;
        3'd6: full = ua ^ ub;
        default: full = ~ua;
      endcase
    end
    full = full & mask;
    r = 32'(full);
    f[0] = cy;
    f[1] = ($countones(r[7:0]) % 2) == 0;
    f[2] = ax;
    f[3] = (full == 0);
    f[4] = ((full >> (w - 1)) & 1) == 1;
    f[5] = ov;
  endfunction

  task automatic drive(input logic [31:0] a, b, input logic [2:0] op,
                       input logic [1:0] ws, input logic cin, input logic we,
                       input string tag);
    logic [31:0] r;
    logic [5:0]  f;
    @(negedge clk);
    opA = a; opB = b; opSel = op; widthSel = ws; carryIn = cin; flagWe = we;
    model(a, b, op, ws, cin, r, f);
    if (we) heldFlags = f;
    qRes.push_back(r);
    qFlg.push_back(heldFlags);
    qTag.push_back(tag);
  endtask

  // monitor: result is combinational, flags load at the edge that follows
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (qRes.size() > 0) begin
        logic [31:0] er;
        logic [5:0]  ef;
        string       t;
        er = qRes.pop_front(); ef = qFlg.pop_front(); t = qTag.pop_front();
        checks++;
        if (result !== er) begin
          errors++;
          $display("FAIL %s result: actual %h expected %h", t, result, er);
        end
        checks++;
        if (flagsQ !== ef) begin
          errors++;
          $display("FAIL %s flags: actual %b expected %b", t, flagsQ, ef);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;  // R9 reset state
    if (flagsQ !== 6'b0) begin
      errors++;
      $display("FAIL R9 reset: actual %b expected %b", flagsQ, 6'b0);
    end
    @(negedge clk);
    rstN = 1'b1;

    drive(32'h0000_00FF, 32'h0000_0001, 3'd0, 2'd0, 1'b0, 1'b1, "R1 add8 wrap");
    drive(32'h0000_007F, 32'h0000_0001, 3'd0, 2'd0, 1'b0, 1'b1, "R3 add8 ovf");
    drive(32'h0000_FFFF, 32'h0000_0000, 3'd1, 2'd1, 1'b1, 1'b1, "R1 adc16");
    drive(32'h0000_0005, 32'h0000_0003, 3'd0, 2'd2, 1'b1, 1'b1, "R10 add ignores cin");
    drive(32'h0000_0009, 32'h0000_0004, 3'd2, 2'd2, 1'b1, 1'b1, "R10 sub ignores cin");
    drive(32'h0000_0000, 32'h0000_0001, 3'd2, 2'd0, 1'b0, 1'b1, "R2 sub8 borrow");
    drive(32'h8000_0000, 32'h0000_0001, 3'd2, 2'd2, 1'b0, 1'b1, "R3 sub32 ovf");
    drive(32'h0000_0010, 32'h0000_000F, 3'd3, 2'd1, 1'b1, 1'b1, "R2 R4 sbb16");
    drive(32'h0000_000F, 32'h0000_0001, 3'd0, 2'd2, 1'b0, 1'b1, "R4 nibble carry");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 3'd4, 2'd2, 1'b1, 1'b1, "R5 and32");
    drive(32'h0000_0080, 32'h0000_0001, 3'd5, 2'd0, 1'b0, 1'b1, "R5 or8");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd6, 2'd1, 1'b0, 1'b1, "R5 R6 xor16 zero");
    drive(32'hFFFF_FF0F, 32'h0000_0000, 3'd7, 2'd0, 1'b1, 1'b1, "R5 R8 not8");
    drive(32'h1234_5680, 32'hABCD_EF80, 3'd0, 2'd0, 1'b0, 1'b1, "R8 upper ignored");
    drive(32'h01FF_0000, 32'h0000_0003, 3'd0, 2'd3, 1'b0, 1'b1, "R7 R8 parity ws3");
    drive(32'h0000_8000, 32'h0000_0000, 3'd5, 2'd1, 1'b0, 1'b1, "R6 sign16");
    drive(32'h0000_0000, 32'h0000_0001, 3'd2, 2'd2, 1'b0, 1'b1, "R9 load");
    drive(32'h0000_0003, 32'h0000_0004, 3'd0, 2'd0, 1'b0, 1'b0, "R9 hold");
    drive(32'h0000_0000, 32'h0000_0000, 3'd4, 2'd1, 1'b0, 1'b0, "R9 hold2");

    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, 3'($urandom), 2'($urandom), 1'($urandom),
            ($urandom % 4) != 0, "random");
    end

    @(negedge clk);
    flagWe = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule